// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a VCO-rate clock by a programmable ratio N and emits one comparison pulse per N input cycles. It is meant to feed a phase/frequency comparator. The ratio is built the way a dual-modulus synthesizer builds it. A prescaler counts either 33 or 32 input cycles per lap. A 5-bit swallow counter keeps the prescaler on the longer lap for the first S laps of every output period. An 11-bit main counter ends the period after M laps. The result is N = 33·S + 32·(M − S) = 32·M + S. For example, N = 10052 is set with M = 314 and S = 4.

The divider runs entirely in the VCO clock domain. Two outputs serve a downstream window generator. One is the modulus-select line, which shows whether the prescaler is on its long lap. The other is a position count, which gives the input cycle index inside the current output period. The M and S values come from an external control latch. The block takes a fresh copy of them only when a period ends, so a period never mixes two settings. A run-enable input held low puts the block in standby. In standby all counters are held cleared and the outputs are quiet.

Top module: `pswal_div`

## Requirements
- R1: With a swallow value S (0..31) and a main value M (32..2047) applied, `fv_out` pulses once every 32·M + S cycles of `vco_clk`.
- R2: Each `fv_out` pulse lasts exactly one `vco_clk` cycle.
- R3: In every output period, `modulus_hi` is 1 for the first 33·S cycles and 0 for the remaining 32·(M − S) cycles.
- R4: `cyc_pos` equals the number of clock edges since the start of the current period. It runs 0 to N−1, and it reads 0 in the cycle in which `fv_out` is 1.
- R5: A change of `main_set`/`swal_set` in the middle of a period leaves that period at the old length. The following periods use the new values.
- R6: A change applied during the last cycle of a period (`cyc_pos` = N−1) already governs the very next period.
- R7: While `run_en` is 0, `fv_out`, `cyc_pos` and `modulus_hi` are 0 from the next edge on. After `run_en` returns to 1, the first pulse comes a full N cycles later, with N taken from the settings present at that time.
- R8: While `rst_n` is 0 at a clock edge, all outputs are 0. After release, the first pulse appears N cycles after the release.
- R9: The ratio holds at the extremes M = 2047, S = 31 (N = 65535) and M = 32, S = 31 (swallow one short of main, N = 1055).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Divided input clock (VCO rate) |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | 1 = counting, 0 = standby with counters cleared |
| main_set | input | 11 | Main count M from the control latch |
| swal_set | input | 5 | Swallow count S from the control latch |
| fv_out | output | 1 | One-cycle comparison pulse at the end of each period |
| modulus_hi | output | 1 | 1 while the prescaler runs its 33-cycle lap |
| cyc_pos | output | 16 | Input-cycle position within the current period |

## Verification
Several patterns are driven. A mid-range setting (M=314, S=4) establishes the basic ratio. S=0 shows that the long lap is never used. S=31 with M=32 leaves only one short lap, and M=2047, S=31 reaches the top of the range. Comparing the counted long-lap cycles against 33·S separates an error in the swallow handling from an error in the main count, which the period length alone cannot do. Settings are changed in mid-period, in the final cycle and during standby. These three cases tell apart when the settings are sampled, and show whether a restart runs a full period.

// File: rtl/pswal_pkg.sv
// Package: shared defaults and the prescaler modulus type for the
// pulse-swallow divider. No state lives here.
package pswal_pkg;

    // Default field widths of the divide-ratio settings
    parameter int unsigned DEF_MAIN_W = 11;
    parameter int unsigned DEF_SWAL_W = 5;

    // Prescaler lap selection
    typedef enum logic {
        MOD_LOW  = 1'b0,   // lap of 2**SWAL_W cycles
        MOD_HIGH = 1'b1    // lap of 2**SWAL_W + 1 cycles
    } pmod_e;

endpackage

// File: rtl/pswal_cfg_hold.sv
// Module: pswal_cfg_hold
// Holds the M/S settings used for the current output period.
// Assumes: the settings inputs are stable in the cycle they are sampled.
// They are sampled on every edge in reset or standby, and on the edge
// that ends a period. They are ignored at all other times.
module pswal_cfg_hold #(
    parameter int unsigned MAIN_W = pswal_pkg::DEF_MAIN_W,
    parameter int unsigned SWAL_W = pswal_pkg::DEF_SWAL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              term,
    input  logic [MAIN_W-1:0] main_set,
    input  logic [SWAL_W-1:0] swal_set,
    output logic [MAIN_W-1:0] main_act,
    output logic [SWAL_W-1:0] swal_act
);

    logic take;
    assign take = !rst_n || !run_en || term;

    // Refresh the active settings only at a period boundary or while idle
    always_ff @(posedge clk) begin
        if (take) begin
            main_act <= main_set;
            swal_act <= swal_set;
        end
    end

endmodule

// File: rtl/pswal_prescaler.sv
// Module: pswal_prescaler
// Dual-modulus prescaler model. It counts laps of 2**SWAL_W or
// 2**SWAL_W + 1 input cycles, as chosen by mod_sel, and flags the last
// cycle of each lap.
// Assumes: mod_sel is stable during a lap (it changes only at lap ends).
module pswal_prescaler
    import pswal_pkg::*;
#(
    parameter int unsigned SWAL_W = DEF_SWAL_W
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run_en,
    input  pmod_e mod_sel,
    output logic  pre_wrap
);

    localparam int unsigned PRE_LOW = 1 << SWAL_W;
    localparam int unsigned PRE_W   = SWAL_W + 1;

    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] last;

    // Last count value of the current lap
    assign last     = (mod_sel == MOD_HIGH) ? PRE_W'(PRE_LOW) : PRE_W'(PRE_LOW - 1);
    assign pre_wrap = (cnt == last);

    // Lap counter, cleared in reset/standby and at the end of each lap
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            cnt <= '0;
        end else if (pre_wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pswal_counters.sv
// Module: pswal_counters
// Swallow and main lap counters. The swallow counter advances on each
// lap until it equals S. The main counter advances on every lap, and the
// period ends on the lap that brings it to M.
// Assumes: M > S, which the legal ranges (M >= 32, S <= 31) guarantee.
module pswal_counters #(
    parameter int unsigned MAIN_W = pswal_pkg::DEF_MAIN_W,
    parameter int unsigned SWAL_W = pswal_pkg::DEF_SWAL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              pre_wrap,
    input  logic [MAIN_W-1:0] main_act,
    input  logic [SWAL_W-1:0] swal_act,
    output logic              swal_done,
    output logic              term
);

    logic [SWAL_W-1:0] swal_cnt;
    logic [MAIN_W-1:0] main_cnt;
    logic [MAIN_W-1:0] main_last;

    assign main_last = main_act - MAIN_W'(1);
    assign swal_done = (swal_cnt == swal_act);
    assign term      = pre_wrap && (main_cnt == main_last);

    // Swallow counter: counts long laps until S of them are done
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en || term) begin
            swal_cnt <= '0;
        end else if (pre_wrap && !swal_done) begin
            swal_cnt <= swal_cnt + 1'b1;
        end
    end

    // Main counter: counts every lap of the period
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en || term) begin
            main_cnt <= '0;
        end else if (pre_wrap) begin
            main_cnt <= main_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pswal_div.sv
// Module: pswal_div (top)
// Pulse-swallow feedback divider: N = 2**SWAL_W * M + S input cycles per
// output pulse. fv_out is registered and one cycle wide. cyc_pos gives the
// cycle index in the period, and modulus_hi the prescaler lap type.
// Assumes: a single clock domain (vco_clk); rst_n and run_en are
// synchronous to it.
module pswal_div
    import pswal_pkg::*;
#(
    parameter int unsigned MAIN_W = DEF_MAIN_W,
    parameter int unsigned SWAL_W = DEF_SWAL_W
) (
    input  logic                     vco_clk,
    input  logic                     rst_n,
    input  logic                     run_en,
    input  logic [MAIN_W-1:0]        main_set,
    input  logic [SWAL_W-1:0]        swal_set,
    output logic                     fv_out,
    output logic                     modulus_hi,
    output logic [MAIN_W+SWAL_W-1:0] cyc_pos
);

    localparam int unsigned DIV_W = MAIN_W + SWAL_W;

    logic [MAIN_W-1:0] main_act;
    logic [SWAL_W-1:0] swal_act;
    logic              pre_wrap;
    logic              swal_done;
    logic              term;
    pmod_e             mod_sel;

    // Long lap while counting and S long laps not yet done
    assign mod_sel    = (rst_n && run_en && !swal_done) ? MOD_HIGH : MOD_LOW;
    assign modulus_hi = (mod_sel == MOD_HIGH);

    pswal_cfg_hold #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) u_cfg (
        .clk      (vco_clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .term     (term),
        .main_set (main_set),
        .swal_set (swal_set),
        .main_act (main_act),
        .swal_act (swal_act)
    );

    pswal_prescaler #(.SWAL_W(SWAL_W)) u_pre (
        .clk      (vco_clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .mod_sel  (mod_sel),
        .pre_wrap (pre_wrap)
    );

    pswal_counters #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) u_cnt (
        .clk       (vco_clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .pre_wrap  (pre_wrap),
        .main_act  (main_act),
        .swal_act  (swal_act),
        .swal_done (swal_done),
        .term      (term)
    );

    // Output pulse, registered from the terminal count
    always_ff @(posedge vco_clk) begin
        if (!rst_n || !run_en) begin
            fv_out <= 1'b0;
        end else begin
            fv_out <= term;
        end
    end

    // Position within the period, restarting together with the pulse
    always_ff @(posedge vco_clk) begin
        if (!rst_n || !run_en || term) begin
            cyc_pos <= '0;
        end else begin
            cyc_pos <= cyc_pos + DIV_W'(1);
        end
    end

endmodule

// File: rtl/pswal_div_chk.sv
// Module: pswal_div_chk
// Checker bound to pswal_div. It watches the ports for the pulse,
// position and standby rules.
module pswal_div_chk #(
    parameter int unsigned DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             fv_out,
    input logic             modulus_hi,
    input logic [DIV_W-1:0] cyc_pos
);

    // R2: pulse lasts one cycle
    p_fv_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fv_out |=> !fv_out);

    // R4: the pulse marks position zero
    p_fv_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fv_out |-> (cyc_pos == '0));

    // R4: a nonzero position is always one more than the previous one
    p_pos_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_pos != '0) |-> (cyc_pos == DIV_W'($past(cyc_pos) + 1'b1)));

    // R3: once the long laps are over they do not return before the period ends
    p_mod_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!modulus_hi && run_en) |=> (!modulus_hi || fv_out));

    // R7: standby clears the pulse and the position
    p_standby_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!fv_out && cyc_pos == '0));

endmodule

bind pswal_div pswal_div_chk #(.DIV_W(DIV_W)) u_chk (
    .clk        (vco_clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .fv_out     (fv_out),
    .modulus_hi (modulus_hi),
    .cyc_pos    (cyc_pos)
);

// File: tb/pswal_div_test.sv
// Scoreboard bench for pswal_div. The driver queues the expected periods,
// and the monitor measures each period at the falling edge and compares.
module pswal_div_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run_en;
    logic [10:0] main_set;
    logic [4:0]  swal_set;
    logic        fv_out;
    logic        modulus_hi;
    logic [15:0] cyc_pos;

    always #4 clk = ~clk;

    pswal_div uut (
        .vco_clk    (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .main_set   (main_set),
        .swal_set   (swal_set),
        .fv_out     (fv_out),
        .modulus_hi (modulus_hi),
        .cyc_pos    (cyc_pos)
    );

    typedef struct {
        int    n;
        int    hi_cyc;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic expect_period(input int m, input int s, input string tag);
        exp_t e;
        e.n      = 32 * m + s;
        e.hi_cyc = 33 * s;
        e.tag    = tag;
        q.push_back(e);
    endtask

    task automatic tick(input int k);
        repeat (k) @(posedge clk);
        #2;
    endtask

    task automatic drain();
        while (q.size() != 0) @(posedge clk);
        #2;
    endtask

    task automatic set_cfg(input int m, input int s);
        main_set = 11'(m);
        swal_set = 5'(s);
    endtask

    task automatic restart(input int m, input int s, input int k, input string tag);
        rst_n = 1'b0;
        set_cfg(m, s);
        tick(2);
        for (int i = 0; i < k; i++) expect_period(m, s, tag);
        rst_n = 1'b1;
        drain();
    endtask

    // Monitor: measure period length, long-lap cycles and position tracking
    initial begin
        int   cyc;
        int   hi;
        int   pos_err;
        bit   fresh;
        bit   after_pulse;
        exp_t e;
        cyc = 0; hi = 0; pos_err = 0; fresh = 1'b1; after_pulse = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst_n || !run_en) begin
                cyc = 0; hi = 0; pos_err = 0; fresh = 1'b1; after_pulse = 1'b0;
            end else begin
                if (fresh) begin
                    cyc = 0;
                    fresh = 1'b0;
                end else begin
                    cyc++;
                end
                if (after_pulse) begin
                    chk(fv_out == 1'b0, "R2", "pulse width", fv_out, 0);
                    after_pulse = 1'b0;
                end
                if (fv_out) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R1", "unexpected pulse at cycle", cyc, 0);
                    end else begin
                        e = q.pop_front();
                        chk(cyc == e.n, e.tag, "period length", cyc, e.n);
                        chk(hi == e.hi_cyc, "R3", "long-lap cycles", hi, e.hi_cyc);
                        chk(pos_err == 0, "R4", "position mismatches", pos_err, 0);
                    end
                    cyc = 0; hi = 0; pos_err = 0;
                    after_pulse = 1'b1;
                end
                if (cyc_pos != 16'(cyc)) pos_err++;
                if (modulus_hi) hi++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            report();
            $finish;
        end
    end

    // Driver
    initial begin
        rst_n  = 1'b0;
        run_en = 1'b1;
        set_cfg(314, 4);
        tick(3);
        @(negedge clk);
        chk(fv_out == 1'b0, "R8", "fv in reset", fv_out, 0);
        chk(cyc_pos == 16'd0, "R8", "position in reset", cyc_pos, 0);
        chk(modulus_hi == 1'b0, "R8", "modulus in reset", modulus_hi, 0);
        tick(1);
        expect_period(314, 4, "R8");
        expect_period(314, 4, "R1");
        rst_n = 1'b1;
        drain();

        // S = 0: long lap never used
        restart(32, 0, 2, "R1");
        // swallow one short of main
        restart(32, 31, 1, "R9");

        // R5: change in the middle of a 1055-cycle period
        expect_period(32, 31, "R5");
        expect_period(40, 7, "R5");
        expect_period(40, 7, "R5");
        tick(500);
        set_cfg(40, 7);
        drain();

        // R6: change during the final cycle of a 1287-cycle period
        expect_period(40, 7, "R6");
        expect_period(33, 1, "R6");
        while (cyc_pos != 16'd1286) tick(1);
        set_cfg(33, 1);
        drain();

        // R7: standby in mid-period, new settings, full period on resume
        tick(300);
        run_en = 1'b0;
        set_cfg(314, 4);
        @(negedge clk);
        chk(modulus_hi == 1'b0, "R7", "modulus in standby", modulus_hi, 0);
        @(negedge clk);
        chk(fv_out == 1'b0, "R7", "fv in standby", fv_out, 0);
        chk(cyc_pos == 16'd0, "R7", "position in standby", cyc_pos, 0);
        tick(20);
        chk(cyc_pos == 16'd0, "R7", "position held in standby", cyc_pos, 0);
        expect_period(314, 4, "R7");
        run_en = 1'b1;
        drain();

        // R9: largest ratio
        restart(2047, 31, 1, "R9");

        done = 1'b1;
        report();
        $finish;
    end

endmodule